// File: doc/BRIEF.md
# Code Verify Scrambler and Lock Gate

This block sits between an on-chip code store and its external read-out path. When a verify is requested, the raw code byte is combined with one byte of a 64-entry key table, chosen by the lowest six address bits. The key byte is combined by bitwise XNOR. A blank key (all ones) therefore passes the code through unchanged. The result appears one clock after the request.

A three-bit lock register selects one of four protection levels, and each level adds to the one below it:

- Level 1 stops any further programming of the part and blocks table reads of internal code by instructions fetched from external memory. It also freezes the external-access strap at the value it had during reset.
- Level 2 also refuses verify reads.
- Level 3 also forbids execution from external memory.

A signature mode returns three fixed identification bytes, and the lock level does not affect it. Both the key table and the lock bits are nonvolatile-style storage. Programming can only clear their bits. An erase strobe is the only way to return them to all ones, and the reset input does not touch them.

Top module: `code_guard`

## Requirements
- R1: The key byte applied to a verify read is the table entry whose index equals bits 5:0 of `vfy_addr`, so addresses that share those six bits use the same key.
- R2: The cycle after a non-signature verify request at lock level 0 or 1, `vfy_valid` is 1 and `vfy_data` equals `~(code_byte ^ key)`; an unprogrammed key of FFH returns `code_byte` itself.
- R3: Lock bits are active low: a bit value of 0 means programmed. `lock_q` = 111 gives level 0, 110 (bit 0 programmed) gives level 1, 100 gives level 2, 000 gives level 3, and every other value gives level 3. `lock_level` reports the level as a 2-bit number.
- R4: At level 1 or above, `prog_ok` and `ext_fetch_ok` are 0 and key-table writes are ignored. At level 0 both flags are 1.
- R5: At level 2 or above, a non-signature verify request returns `vfy_data` = 00H with `vfy_deny` = 1 in the following cycle.
- R6: `ext_exec_ok` is 0 exactly at level 3.
- R7: A request with `sig_mode` = 1 returns 89H for address 030H, 58H for 031H, 54H for 060H and 00H for any other address, at any lock level and never with `vfy_deny` set.
- R8: `erase` sets every key byte and all lock bits to 1 at the next edge, taking priority over a key or lock write in the same cycle.
- R9: At level 0, `ea_eff` follows `ea_pin`. At level 1 or above, `ea_eff` holds the value `ea_pin` had in the last clock cycle with `rst_n` low.
- R10: A key write stores `old & key_wdata` and a lock write stores `old & lock_wdata`. Writes only clear bits.
- R11: In a cycle after no request, `vfy_valid`, `vfy_deny` and `vfy_data` are all 0.
- R12: While `rst_n` is low (synchronous), `vfy_valid`, `vfy_deny` and `vfy_data` are 0 at the next edge. The key table and lock bits are kept through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ea_pin | input | 1 | External-access strap level |
| erase | input | 1 | Return keys and lock bits to all ones |
| key_we | input | 1 | Key table write strobe |
| key_waddr | input | 6 | Key table write index |
| key_wdata | input | 8 | Key write data (bits at 0 are cleared) |
| lock_we | input | 1 | Lock bit write strobe |
| lock_wdata | input | 3 | Lock write data (bits at 0 are programmed) |
| vfy_req | input | 1 | Verify read request |
| sig_mode | input | 1 | Request reads a signature byte |
| vfy_addr | input | 14 | Verify address |
| code_byte | input | 8 | Raw code byte at `vfy_addr` |
| vfy_valid | output | 1 | Read result present |
| vfy_deny | output | 1 | Read refused by lock |
| vfy_data | output | 8 | Scrambled code, signature or 00H |
| lock_level | output | 2 | Current protection level 0..3 |
| prog_ok | output | 1 | Programming permitted |
| ext_fetch_ok | output | 1 | Externally fetched table reads may see internal code |
| ext_exec_ok | output | 1 | Execution from external memory permitted |
| ea_eff | output | 1 | External-access value in effect |

## Verification
A corrupted key entry shows up only when a verify read selects that index. It appears one cycle after the request as wrong bits in `vfy_data`, so the reference model keeps its own copy of the table and tests every index through aliased addresses. A wrong lock value shows up at once, in the same cycle, on `lock_level` and the three permission flags. It also decides whether the next verify returns data or a denial. A stale external-access latch is exposed only after the part is locked and the strap pin has changed since reset.

// File: rtl/code_guard.sv
module code_guard #(
  parameter int AW   = 14,
  parameter int DW   = 8,
  parameter int KEYS = 64,
  localparam int KW  = $clog2(KEYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ea_pin,
  input  logic          erase,
  input  logic          key_we,
  input  logic [KW-1:0] key_waddr,
  input  logic [DW-1:0] key_wdata,
  input  logic          lock_we,
  input  logic [2:0]    lock_wdata,
  input  logic          vfy_req,
  input  logic          sig_mode,
  input  logic [AW-1:0] vfy_addr,
  input  logic [DW-1:0] code_byte,
  output logic          vfy_valid,
  output logic          vfy_deny,
  output logic [DW-1:0] vfy_data,
  output logic [1:0]    lock_level,
  output logic          prog_ok,
  output logic          ext_fetch_ok,
  output logic          ext_exec_ok,
  output logic          ea_eff
);

  logic [DW-1:0] key_mem [KEYS];
  logic [2:0]    lock_q;
  logic          ea_q;
  logic [1:0]    lvl;
  logic [DW-1:0] sig_byte;
  logic [DW-1:0] scrambled;

  always_comb begin
    case (lock_q)
      3'b111:  lvl = 2'd0;
      3'b110:  lvl = 2'd1;
      3'b100:  lvl = 2'd2;
      default: lvl = 2'd3;
    endcase
  end

  always_comb begin
    if      (vfy_addr == AW'(12'h030)) sig_byte = DW'(8'h89);
    else if (vfy_addr == AW'(12'h031)) sig_byte = DW'(8'h58);
    else if (vfy_addr == AW'(12'h060)) sig_byte = DW'(8'h54);
    else                               sig_byte = '0;
  end

  assign scrambled    = ~(code_byte ^ key_mem[vfy_addr[KW-1:0]]);
  assign lock_level   = lvl;
  assign prog_ok      = (lvl == 2'd0);
  assign ext_fetch_ok = (lvl == 2'd0);
  assign ext_exec_ok  = (lvl != 2'd3);
  assign ea_eff       = (lvl == 2'd0) ? ea_pin : ea_q;

  always_ff @(posedge clk) begin
    if (erase) begin
      for (int i = 0; i < KEYS; i++) key_mem[i] <= '1;
      lock_q <= '1;
    end else begin
      if (key_we && lvl == 2'd0) key_mem[key_waddr] <= key_mem[key_waddr] & key_wdata;
      if (lock_we) lock_q <= lock_q & lock_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vfy_valid <= 1'b0;
      vfy_deny  <= 1'b0;
      vfy_data  <= '0;
      ea_q      <= ea_pin;
    end else begin
      vfy_valid <= vfy_req;
      vfy_deny  <= vfy_req && !sig_mode && lvl >= 2'd2;
      if (!vfy_req)         vfy_data <= '0;
      else if (sig_mode)    vfy_data <= sig_byte;
      else if (lvl >= 2'd2) vfy_data <= '0;
      else                  vfy_data <= scrambled;
    end
  end

  a_r3_cumulative: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_exec_ok |-> (!prog_ok && !ext_fetch_ok));

  a_r5_locked_verify: assert property (@(posedge clk) disable iff (!rst_n)
    (vfy_req && !sig_mode && lock_level >= 2'd2) |=> (vfy_deny && vfy_data == '0));

  a_r7_sig_never_denied: assert property (@(posedge clk) disable iff (!rst_n)
    (vfy_req && sig_mode) |=> (vfy_valid && !vfy_deny));

  a_r8_erase_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (lock_level == 2'd0 && prog_ok));

  a_r10_lock_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !erase |=> ((lock_q & ~$past(lock_q)) == 3'b000));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !vfy_req |=> (!vfy_valid && !vfy_deny && vfy_data == '0));

endmodule

// File: tb/tb_code_guard.sv
module tb_code_guard;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst_n, ea_pin, erase, key_we, lock_we, vfy_req, sig_mode;
  logic [5:0] key_waddr;
  logic [7:0] key_wdata, code_byte;
  logic [2:0] lock_wdata;
  logic [13:0] vfy_addr;
  logic vfy_valid, vfy_deny, prog_ok, ext_fetch_ok, ext_exec_ok, ea_eff;
  logic [7:0] vfy_data;
  logic [1:0] lock_level;

  code_guard dut (.*);

  int checks = 0, errors = 0;
  int mk[64];
  int ml = 7;
  int mea = 0;
  int ev = 0, ed = 0, edat = 0;
  bit done = 0;

  function automatic int level_of(int l);
    case (l)
      7: return 0;
      6: return 1;
      4: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int sig_of(int a);
    if (a == 'h30) return 'h89;
    if (a == 'h31) return 'h58;
    if (a == 'h60) return 'h54;
    return 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model();
    int lv = level_of(ml);
    if (!rst_n) begin
      ev = 0; ed = 0; edat = 0; mea = ea_pin;
    end else begin
      ev = vfy_req;
      ed = vfy_req && !sig_mode && lv >= 2;
      if (!vfy_req) edat = 0;
      else if (sig_mode) edat = sig_of(vfy_addr);
      else if (lv >= 2) edat = 0;
      else edat = (~(code_byte ^ mk[vfy_addr % 64])) & 'hFF;
    end
    if (erase) begin
      foreach (mk[i]) mk[i] = 'hFF;
      ml = 7;
    end else begin
      if (key_we && lv == 0) mk[key_waddr] = mk[key_waddr] & key_wdata;
      if (lock_we) ml = ml & lock_wdata;
    end
  endtask

  task automatic cyc();
    int lv;
    @(posedge clk);
    model();
    @(negedge clk);
    lv = level_of(ml);
    chk("R11 R12 vfy_valid", vfy_valid, ev);
    chk("R5 R7 vfy_deny", vfy_deny, ed);
    chk("R1 R2 R7 vfy_data", vfy_data, edat);
    chk("R3 lock_level", lock_level, lv);
    chk("R4 prog_ok", prog_ok, lv == 0);
    chk("R4 ext_fetch_ok", ext_fetch_ok, lv == 0);
    chk("R6 ext_exec_ok", ext_exec_ok, lv != 3);
    chk("R9 ea_eff", ea_eff, lv == 0 ? ea_pin : mea);
  endtask

  task automatic idle();
    erase = 0; key_we = 0; lock_we = 0; vfy_req = 0; sig_mode = 0;
  endtask

  task automatic rd(int a, int c, bit s);
    idle(); vfy_req = 1; vfy_addr = 14'(a); code_byte = 8'(c); sig_mode = s; cyc();
  endtask

  task automatic kw(int a, int d);
    idle(); key_we = 1; key_waddr = 6'(a); key_wdata = 8'(d); cyc();
  endtask

  task automatic lw(int d);
    idle(); lock_we = 1; lock_wdata = 3'(d); cyc();
  endtask

  task automatic rnd(int n, bit locks);
    for (int i = 0; i < n; i++) begin
      rst_n = ($urandom % 200) != 0;
      ea_pin = $urandom % 2;
      erase = locks && ($urandom % 128) == 0;
      key_we = ($urandom % 4) == 0;
      key_waddr = 6'($urandom); key_wdata = 8'($urandom | $urandom);
      lock_we = locks && ($urandom % 64) == 0;
      lock_wdata = 3'($urandom | $urandom);
      vfy_req = ($urandom % 3) != 0;
      sig_mode = ($urandom % 8) == 0;
      case ($urandom % 4)
        0: vfy_addr = 14'h030;
        1: vfy_addr = 14'($urandom % 128);
        default: vfy_addr = 14'($urandom);
      endcase
      code_byte = 8'($urandom);
      cyc();
    end
    rst_n = 1;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    foreach (mk[i]) mk[i] = 'hFF;
    idle(); key_waddr = 0; key_wdata = 0; lock_wdata = 7; vfy_addr = 0; code_byte = 0;
    rst_n = 0; ea_pin = 1; erase = 1;
    cyc();
    erase = 0; cyc(); cyc();
    rst_n = 1; cyc();
    rd('h012, 'hA5, 0);          // R2 blank key passes code
    idle(); cyc();               // R11
    kw(5, 'h0F); kw(5, 'hF3);    // R10 key becomes 03
    rd('h045, 'h5A, 0);          // R1 alias of index 5
    rd('h005, 'h00, 0);
    rd('h030, 0, 1); rd('h031, 0, 1); rd('h060, 0, 1); rd('h061, 0, 1); // R7
    rnd(300, 0);
    lw(3'b110);                  // R3 level 1
    kw(7, 'h00); rd('h007, 'h3C, 0);   // R4 write ignored
    idle(); ea_pin = 0; rst_n = 0; cyc(); cyc();
    rst_n = 1; ea_pin = 1; cyc(); cyc();   // R9 latched 0
    lw(3'b101);                  // level 2
    rd('h007, 'h3C, 0);          // R5 denied
    rd('h031, 0, 1);             // R7 still readable
    lw(3'b011);                  // level 3, R6
    rd('h010, 'h11, 0);
    idle(); erase = 1; key_we = 1; key_waddr = 5; key_wdata = 0; lock_we = 1; lock_wdata = 0; cyc(); // R8
    rd('h005, 'h77, 0);
    lw(3'b101);                  // R3 undefined combination -> level 3
    rd('h005, 'h77, 0);
    idle(); erase = 1; cyc();
    rnd(3000, 1);
    idle(); cyc();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule